// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the architectural state changes a processor core makes when it enters an exception handler. The core presents a request with a 12-bit cause code and a vector class (general, TLB miss or external interrupt), and also presents its current program counter, status word, stack register R15 and vector base. In one clock edge the sequencer captures the return state into its saved-PC, saved-status and saved-stack registers and records the cause. It then produces the handler address, the fetch address that follows it, and the privileged status word that the core loads.

The sequencer also owns the branch-delay-slot flag. The decoder arms it when a delayed branch issues and clears it when the slot instruction retires. If an exception is taken while the flag is set, the saved PC is moved back one 16-bit instruction so that the handler returns to the branch. A trap request stores its scaled immediate in a trap register and resumes after the trap instruction. A vector base of zero is treated as a fatal configuration error: the block raises a sticky halt and performs no entry.

Top module: `exc_entry_seq`

## Requirements
- R1: After synchronous reset every saved register, the handler PC, the follow-on PC, the new status, the trap register, `entry_done`, `halted` and `in_slot` all read zero.
- R2: When a request is accepted, the next clock edge loads `saved_pc`, `saved_sr` and `saved_r15` from `cur_pc`, `cur_sr` and `cur_r15`, and `entry_done` is high for exactly that one following cycle.
- R3: The same edge loads `cause_reg` with the request's 12-bit cause code. For a trap it loads 0x160 instead.
- R4: `handler_pc` is `vbr` plus an offset chosen by `req_class`: 0 (general) gives 0x100, 1 (TLB miss) gives 0x400, 2 (interrupt) gives 0x600, and 3 is handled like 0.
- R5: `fetch_pc` equals `handler_pc` plus 2.
- R6: `new_sr` equals the captured status with bit 30 (privileged mode), bit 29 (register bank) and bit 28 (block) forced to 1.
- R7: A `slot_arm` pulse sets `in_slot` and a `slot_retire` pulse clears it. An entry clears it, and an entry takes precedence over `slot_arm`. An entry taken while `in_slot` is set saves `cur_pc - 2`.
- R8: A request made while `vbr` is zero sets `halted`, which stays set until reset. It changes no saved register, and every later request is ignored.
- R9: A trap request (`req_trap`=1) loads `trap_reg` with `trap_imm` shifted left by 2 (bits 9:2) and uses the general vector. It saves `cur_pc + 2`, or `cur_pc` when `in_slot` is set. `trap_reg` is left unchanged by entries that are not traps.
- R10: A request presented while `entry_done` is high is ignored, and the saved registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request |
| req_class | input | 2 | Vector class: 0 general, 1 TLB miss, 2 interrupt |
| req_cause | input | 12 | Cause code |
| req_trap | input | 1 | Request comes from a trap instruction |
| trap_imm | input | 8 | Trap immediate |
| cur_pc | input | 32 | PC of the faulting instruction |
| cur_sr | input | 32 | Current status word |
| cur_r15 | input | 32 | Current stack register |
| vbr | input | 32 | Vector base |
| slot_arm | input | 1 | Delayed branch issued |
| slot_retire | input | 1 | Delay-slot instruction retired |
| saved_pc | output | 32 | Saved return PC |
| saved_sr | output | 32 | Saved status |
| saved_r15 | output | 32 | Saved stack register |
| cause_reg | output | 12 | Recorded cause |
| trap_reg | output | 32 | Scaled trap immediate |
| handler_pc | output | 32 | PC to load |
| fetch_pc | output | 32 | Next fetch address |
| new_sr | output | 32 | Status word to load |
| entry_done | output | 1 | One-cycle entry pulse |
| halted | output | 1 | Sticky zero-vector-base halt |
| in_slot | output | 1 | Delay-slot flag |

## Verification
The hardest situations to reach are the ones where the delay-slot flag interacts with an entry. These include a trap raised from inside a slot, where the +2 and -2 corrections cancel, and a `slot_arm` that arrives in the same cycle as an accepted request. The stimulus arms the flag through `slot_arm` and then raises the request, either one cycle later or in the same cycle. It also arms and retires the flag before a request to show that a retired slot leaves no correction behind. Back-to-back requests are made by holding `req_valid` for two cycles while `cur_pc` changes, and the halt case is reached last by presenting a zero vector base.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int WORD_W  = 32;
    localparam int CAUSE_W = 12;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [CAUSE_W-1:0] cause_t;

    typedef enum logic [1:0] {
        VEC_GENERAL = 2'd0,
        VEC_TLB     = 2'd1,
        VEC_IRQ     = 2'd2,
        VEC_RSVD    = 2'd3
    } vec_class_e;

    localparam cause_t TRAP_CAUSE = 12'h160;

    typedef struct packed {
        word_t  spc;
        word_t  ssr;
        word_t  sgr;
        word_t  tra;
        word_t  new_pc;
        word_t  next_pc;
        word_t  new_sr;
        cause_t expevt;
        logic   tra_wr;
    } entry_t;

    function automatic word_t vec_offset(vec_class_e c);
        case (c)
            VEC_TLB: vec_offset = 32'h0000_0400;
            VEC_IRQ: vec_offset = 32'h0000_0600;
            default: vec_offset = 32'h0000_0100;
        endcase
    endfunction

endpackage

// File: rtl/exc_slot_tracker.sv
module exc_slot_tracker (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic retire,
    input  logic entry,
    output logic in_slot
);
    always_ff @(posedge clk) begin
        if (rst)         in_slot <= 1'b0;
        else if (entry)  in_slot <= 1'b0;
        else if (arm)    in_slot <= 1'b1;
        else if (retire) in_slot <= 1'b0;
    end
endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
    import exc_pkg::*;
#(
    parameter int SR_MD_BIT  = 30,
    parameter int SR_RB_BIT  = 29,
    parameter int SR_BL_BIT  = 28,
    parameter int INSN_BYTES = 2,
    parameter int TRAP_SHIFT = 2
) (
    input  word_t      vbr,
    input  word_t      pc,
    input  word_t      sr,
    input  word_t      r15,
    input  vec_class_e cls,
    input  logic       is_trap,
    input  cause_t     cause,
    input  logic [7:0] trap_imm,
    input  logic       in_slot,
    output entry_t     ent
);
    localparam word_t STEP      = word_t'(INSN_BYTES);
    localparam word_t PRIV_MASK = (word_t'(1) << SR_MD_BIT) |
                                  (word_t'(1) << SR_RB_BIT) |
                                  (word_t'(1) << SR_BL_BIT);

    word_t      resume_pc;
    vec_class_e eff_cls;

    always_comb begin
        resume_pc   = is_trap ? pc + STEP : pc;
        eff_cls     = is_trap ? VEC_GENERAL : cls;
        ent.spc     = in_slot ? resume_pc - STEP : resume_pc;
        ent.ssr     = sr;
        ent.sgr     = r15;
        ent.tra     = word_t'(trap_imm) << TRAP_SHIFT;
        ent.tra_wr  = is_trap;
        ent.expevt  = is_trap ? TRAP_CAUSE : cause;
        ent.new_pc  = vbr + vec_offset(eff_cls);
        ent.next_pc = ent.new_pc + STEP;
        ent.new_sr  = sr | PRIV_MASK;
    end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  entry_t ent,
    output entry_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= ent;
            if (!ent.tra_wr) q.tra <= q.tra;
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int SR_MD_BIT  = 30,
    parameter int SR_RB_BIT  = 29,
    parameter int SR_BL_BIT  = 28,
    parameter int INSN_BYTES = 2,
    parameter int TRAP_SHIFT = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_class,
    input  logic [11:0] req_cause,
    input  logic        req_trap,
    input  logic [7:0]  trap_imm,
    input  logic [31:0] cur_pc,
    input  logic [31:0] cur_sr,
    input  logic [31:0] cur_r15,
    input  logic [31:0] vbr,
    input  logic        slot_arm,
    input  logic        slot_retire,
    output logic [31:0] saved_pc,
    output logic [31:0] saved_sr,
    output logic [31:0] saved_r15,
    output logic [11:0] cause_reg,
    output logic [31:0] trap_reg,
    output logic [31:0] handler_pc,
    output logic [31:0] fetch_pc,
    output logic [31:0] new_sr,
    output logic        entry_done,
    output logic        halted,
    output logic        in_slot
);
    logic   req_live;
    logic   vbr_zero;
    logic   accept;
    logic   halt_set;
    entry_t ent_d;
    entry_t ent_q;

    // A request counts only when the previous entry is not being signalled
    // and the block has not halted.
    assign req_live = req_valid && !entry_done && !halted;
    assign vbr_zero = (vbr == '0);
    assign accept   = req_live && !vbr_zero;
    assign halt_set = req_live && vbr_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_done <= 1'b0;
            halted     <= 1'b0;
        end else begin
            entry_done <= accept;
            if (halt_set) halted <= 1'b1;
        end
    end

    exc_slot_tracker u_slot (
        .clk     (clk),
        .rst     (rst),
        .arm     (slot_arm),
        .retire  (slot_retire),
        .entry   (accept),
        .in_slot (in_slot)
    );

    exc_target_calc #(
        .SR_MD_BIT  (SR_MD_BIT),
        .SR_RB_BIT  (SR_RB_BIT),
        .SR_BL_BIT  (SR_BL_BIT),
        .INSN_BYTES (INSN_BYTES),
        .TRAP_SHIFT (TRAP_SHIFT)
    ) u_calc (
        .vbr      (vbr),
        .pc       (cur_pc),
        .sr       (cur_sr),
        .r15      (cur_r15),
        .cls      (vec_class_e'(req_class)),
        .is_trap  (req_trap),
        .cause    (req_cause),
        .trap_imm (trap_imm),
        .in_slot  (in_slot),
        .ent      (ent_d)
    );

    exc_state_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .ent  (ent_d),
        .q    (ent_q)
    );

    assign saved_pc   = ent_q.spc;
    assign saved_sr   = ent_q.ssr;
    assign saved_r15  = ent_q.sgr;
    assign cause_reg  = ent_q.expevt;
    assign trap_reg   = ent_q.tra;
    assign handler_pc = ent_q.new_pc;
    assign fetch_pc   = ent_q.next_pc;
    assign new_sr     = ent_q.new_sr;
endmodule

// File: rtl/exc_entry_checks.sv
module exc_entry_checks #(
    parameter int SR_MD_BIT = 30,
    parameter int SR_RB_BIT = 29,
    parameter int SR_BL_BIT = 28
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] saved_pc,
    input logic [31:0] saved_sr,
    input logic [11:0] cause_reg,
    input logic [31:0] handler_pc,
    input logic [31:0] fetch_pc,
    input logic [31:0] new_sr,
    input logic        entry_done,
    input logic        halted,
    input logic        in_slot
);
    localparam logic [31:0] MASK = (32'd1 << SR_MD_BIT) |
                                   (32'd1 << SR_RB_BIT) |
                                   (32'd1 << SR_BL_BIT);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!entry_done && !halted && !in_slot && saved_pc == 32'd0));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        entry_done |=> !entry_done);

    p_fetch_step_r5: assert property (@(posedge clk) disable iff (rst)
        entry_done |-> fetch_pc == handler_pc + 32'd2);

    p_priv_sr_r6: assert property (@(posedge clk) disable iff (rst)
        entry_done |-> new_sr == (saved_sr | MASK));

    p_slot_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        entry_done |-> !in_slot);

    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_halt_no_entry_r8: assert property (@(posedge clk) disable iff (rst)
        halted |-> !entry_done);

    p_busy_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        entry_done |=> ($stable(saved_pc) && $stable(cause_reg)));
endmodule

bind exc_entry_seq exc_entry_checks #(
    .SR_MD_BIT (SR_MD_BIT),
    .SR_RB_BIT (SR_RB_BIT),
    .SR_BL_BIT (SR_BL_BIT)
) u_checks (
    .clk        (clk),
    .rst        (rst),
    .saved_pc   (saved_pc),
    .saved_sr   (saved_sr),
    .cause_reg  (cause_reg),
    .handler_pc (handler_pc),
    .fetch_pc   (fetch_pc),
    .new_sr     (new_sr),
    .entry_done (entry_done),
    .halted     (halted),
    .in_slot    (in_slot)
);

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_class = 2'd0;
    logic [11:0] req_cause = 12'd0;
    logic        req_trap = 1'b0;
    logic [7:0]  trap_imm = 8'd0;
    logic [31:0] cur_pc = 32'd0, cur_sr = 32'd0, cur_r15 = 32'd0, vbr = 32'd0;
    logic        slot_arm = 1'b0, slot_retire = 1'b0;
    logic [31:0] saved_pc, saved_sr, saved_r15, trap_reg, handler_pc, fetch_pc, new_sr;
    logic [11:0] cause_reg;
    logic        entry_done, halted, in_slot;

    int total = 0;
    int fails = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    exc_entry_seq dut (.*);

    // behavioural reference model
    logic [31:0] m_spc = 0, m_ssr = 0, m_sgr = 0, m_tra = 0, m_npc = 0, m_fpc = 0, m_nsr = 0;
    logic [11:0] m_cause = 0;
    logic        m_done = 0, m_halt = 0, m_slot = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_spc = 0; m_ssr = 0; m_sgr = 0; m_tra = 0; m_npc = 0; m_fpc = 0; m_nsr = 0;
            m_cause = 0; m_done = 0; m_halt = 0; m_slot = 0;
        end else begin
            bit take;
            take = req_valid && !m_done && !m_halt;
            if (take && vbr == 0) begin
                m_halt = 1; take = 0;
            end
            if (take) begin
                m_spc = cur_pc + (req_trap ? 32'd2 : 32'd0) - (m_slot ? 32'd2 : 32'd0);
                m_ssr = cur_sr;
                m_sgr = cur_r15;
                m_nsr = cur_sr | 32'h7000_0000;
                m_cause = req_trap ? 12'h160 : req_cause;
                if (req_trap) m_tra = {22'd0, trap_imm, 2'b00};
                if (req_trap || req_class == 2'd0 || req_class == 2'd3) m_npc = vbr + 32'h100;
                else if (req_class == 2'd1) m_npc = vbr + 32'h400;
                else m_npc = vbr + 32'h600;
                m_fpc = m_npc + 32'd2;
                m_slot = 0;
            end else if (slot_arm) m_slot = 1;
            else if (slot_retire) m_slot = 0;
            m_done = take;
        end
    end

    task automatic cmp(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!rst && !ended) begin
        cmp("R2", "saved_pc",   saved_pc,   m_spc);
        cmp("R2", "saved_sr",   saved_sr,   m_ssr);
        cmp("R2", "saved_r15",  saved_r15,  m_sgr);
        cmp("R3", "cause_reg",  {20'd0, cause_reg}, {20'd0, m_cause});
        cmp("R9", "trap_reg",   trap_reg,   m_tra);
        cmp("R4", "handler_pc", handler_pc, m_npc);
        cmp("R5", "fetch_pc",   fetch_pc,   m_fpc);
        cmp("R6", "new_sr",     new_sr,     m_nsr);
        cmp("R2", "entry_done", {31'd0, entry_done}, {31'd0, m_done});
        cmp("R8", "halted",     {31'd0, halted},     {31'd0, m_halt});
        cmp("R7", "in_slot",    {31'd0, in_slot},    {31'd0, m_slot});
    end

    task automatic fire(input logic [1:0] cls, input logic [11:0] cause, input logic trap,
                        input logic [7:0] imm, input logic [31:0] pc, input logic [31:0] sr);
        req_class = cls; req_cause = cause; req_trap = trap; trap_imm = imm;
        cur_pc = pc; cur_sr = sr; cur_r15 = pc ^ 32'h5A5A_0000;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_trap = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        ended = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", "reset saved_pc", saved_pc, 32'd0);
        cmp("R1", "reset flags", {29'd0, entry_done, halted, in_slot}, 32'd0);
        cmp("R1", "reset handler_pc", handler_pc, 32'd0);
        rst = 1'b0;
        vbr = 32'h8C00_0000;
        idle(1);

        // R2 R3 R4 R6: general exception
        fire(2'd0, 12'h0E0, 1'b0, 8'd0, 32'h8C00_10A0, 32'h0000_00F1);
        cmp("R2", "general saved_pc", saved_pc, 32'h8C00_10A0);
        cmp("R3", "general cause", {20'd0, cause_reg}, 32'h0E0);
        cmp("R4", "general vector", handler_pc, 32'h8C00_0100);
        cmp("R6", "general new_sr", new_sr, 32'h7000_00F1);
        idle(2);

        // R4 R5: TLB miss and interrupt classes, reserved class
        fire(2'd1, 12'h040, 1'b0, 8'd0, 32'h8C00_2000, 32'h4000_0000);
        cmp("R4", "tlb vector", handler_pc, 32'h8C00_0400);
        cmp("R5", "tlb fetch", fetch_pc, 32'h8C00_0402);
        idle(1);
        fire(2'd2, 12'h320, 1'b0, 8'd0, 32'h8C00_2100, 32'h0);
        cmp("R4", "irq vector", handler_pc, 32'h8C00_0600);
        idle(1);
        fire(2'd3, 12'h1E0, 1'b0, 8'd0, 32'h8C00_2200, 32'h0);
        cmp("R4", "reserved class vector", handler_pc, 32'h8C00_0100);
        idle(1);

        // R10: held request, second cycle ignored
        req_class = 2'd0; req_cause = 12'h0A0; cur_pc = 32'h8C00_3000; req_valid = 1'b1;
        @(negedge clk);
        cur_pc = 32'h8C00_3F00; req_cause = 12'h0C0;
        @(negedge clk);
        req_valid = 1'b0;
        cmp("R10", "held request saved_pc", saved_pc, 32'h8C00_3000);
        cmp("R10", "held request done", {31'd0, entry_done}, 32'd0);
        idle(1);

        // R7: entry inside a delay slot
        slot_arm = 1'b1; @(negedge clk); slot_arm = 1'b0;
        cmp("R7", "armed", {31'd0, in_slot}, 32'd1);
        fire(2'd0, 12'h180, 1'b0, 8'd0, 32'h8C00_4002, 32'h0);
        cmp("R7", "slot saved_pc", saved_pc, 32'h8C00_4000);
        cmp("R7", "slot flag cleared", {31'd0, in_slot}, 32'd0);
        idle(1);

        // R7: retired slot leaves no correction
        slot_arm = 1'b1; @(negedge clk); slot_arm = 1'b0;
        slot_retire = 1'b1; @(negedge clk); slot_retire = 1'b0;
        fire(2'd0, 12'h180, 1'b0, 8'd0, 32'h8C00_5002, 32'h0);
        cmp("R7", "retired slot saved_pc", saved_pc, 32'h8C00_5002);
        idle(1);

        // R7: arm in the same cycle as an accepted entry, entry wins
        slot_arm = 1'b1;
        fire(2'd0, 12'h100, 1'b0, 8'd0, 32'h8C00_5800, 32'h0);
        slot_arm = 1'b0;
        cmp("R7", "entry beats arm", {31'd0, in_slot}, 32'd0);
        idle(1);

        // R9: trap
        fire(2'd1, 12'h000, 1'b1, 8'h3F, 32'h8C00_6000, 32'h0);
        cmp("R9", "trap_reg", trap_reg, 32'h0000_00FC);
        cmp("R9", "trap cause", {20'd0, cause_reg}, 32'h160);
        cmp("R9", "trap saved_pc", saved_pc, 32'h8C00_6002);
        cmp("R9", "trap vector", handler_pc, 32'h8C00_0100);
        idle(1);
        fire(2'd0, 12'h0E0, 1'b0, 8'h11, 32'h8C00_6100, 32'h0);
        cmp("R9", "non-trap keeps trap_reg", trap_reg, 32'h0000_00FC);
        idle(1);

        // R9 R7: trap inside a slot
        slot_arm = 1'b1; @(negedge clk); slot_arm = 1'b0;
        fire(2'd0, 12'h000, 1'b1, 8'h80, 32'h8C00_7000, 32'h0);
        cmp("R9", "slot trap saved_pc", saved_pc, 32'h8C00_7000);
        cmp("R9", "slot trap_reg", trap_reg, 32'h0000_0200);
        idle(1);

        // R8: zero vector base halts
        vbr = 32'd0;
        fire(2'd0, 12'h0E0, 1'b0, 8'd0, 32'h1234_0000, 32'h0);
        cmp("R8", "halted", {31'd0, halted}, 32'd1);
        cmp("R8", "no entry on halt", saved_pc, 32'h8C00_7000);
        vbr = 32'h8C00_0000;
        fire(2'd0, 12'h0E0, 1'b0, 8'd0, 32'h5678_0000, 32'h0);
        cmp("R8", "ignored after halt", saved_pc, 32'h8C00_7000);
        cmp("R8", "still halted", {31'd0, halted}, 32'd1);
        idle(2);
        finish_run();
    end
endmodule